// File: doc/BRIEF.md
# Interrupt and Timer Controller

This peripheral sits on a processor's I/O window and combines a free-running instruction counter, two compare registers and the interrupt decision. Software reaches eight 32-bit registers over a simple register bus: the handler entry address, the cause flags, the enable mask, the global enable, the saved return address, the counter and the two compare values. The core pulses `step` once per instruction slot. It drives `in_delay_slot` when the slot follows a jump or branch, and it presents the slot's PC on `pc_cur`.

The block raises cause flags in three ways. Four flags are level taps of counter bits 16 and 18 and their inverses. One flag is a full 32-bit compare match. One flag is a match on only the low 24 bits of the second compare register. A nonzero write to the global enable passes through a four-stage delay line that advances on instruction steps. A zero write disables at once. When the enable is set, the masked cause is nonzero and the slot is not a delay slot, `take_irq` is asserted with that step. The return address is then saved, and the next slot is flagged as squashed.

Top module: `irq_timer_ctrl`

## Requirements
- R1: The registers sit at bus offsets 0x00 handler address, 0x10 cause, 0x20 mask, 0x30 global enable, 0x40 return address, 0x50 counter, 0x60 compare, 0x70 compare2. Each one reads back what was last written, except as R3 to R8 say. After reset every register reads zero, and cause reads 0xC0.
- R2: On a normal step (one that neither takes an interrupt nor is squashed), the counter adds one. Without a step, the counter holds its value.
- R3: When the counter value after a normal step equals compare in all 32 bits, cause bit 4 is set and stays set. A write to compare clears cause bit 4.
- R4: When bits 23:0 of the counter value after a normal step equal bits 23:0 of compare2, cause bit 5 is set and stays set, whatever bits 31:24 hold. A write to compare2 clears cause bit 5.
- R5: On each normal step, cause bit 2 is set to counter bit 16 and bit 3 to its inverse. Cause bit 0 is set to counter bit 18 and bit 1 to its inverse. All four use the incremented counter value.
- R6: A read of cause always returns bits 7 and 6 as 1. These are the tied-high external sources.
- R7: A zero write to the global enable clears the enable and every delay stage in the same cycle. A nonzero value written there appears in the enable after exactly four further steps. Cycles without a step do not advance it. The last stage keeps the value, so the enable stays set.
- R8: When `step` is high, the enable is nonzero, cause & mask is nonzero and `in_delay_slot` is low, `take_irq` is high in that cycle and `irq_target` equals the handler address. On the clock edge, the return address becomes `pc_cur`+4 and the enable and delay line clear. The counter does not advance on that step.
- R9: `take_irq` is never high while `in_delay_slot` is high. Such a slot counts as a normal step.
- R10: The step after a taken interrupt sees `squash` high. It advances the delay line but not the counter or the cause flags. `squash` drops after that step.
- R11: A bus write to cause or to the counter in the same cycle as a normal step wins over the hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset in the I/O window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| step | input | 1 | One pulse per instruction slot |
| in_delay_slot | input | 1 | Current slot follows a jump or branch |
| pc_cur | input | 32 | PC of the current slot |
| take_irq | output | 1 | Interrupt taken on this step |
| irq_target | output | 32 | Handler address for the next PC |
| squash | output | 1 | Current slot is squashed after a taken interrupt |

## Verification
The assertions check these rules on every cycle:
- cause bits 7:6 are always forced high on read;
- no interrupt is taken in a delay slot;
- a take clears the enable, loads the return address and squashes the next slot;
- the counter moves exactly one per normal step and holds otherwise.

The bench scenarios cover what needs a history of several steps:
- the exact four-step latency of the enable, and that idle cycles do not advance it;
- the sticky last stage;
- compare2 matching across the 24-bit wrap with arbitrary high bytes;
- the tap flags swept across the bit-16 and bit-18 transitions;
- bus writes winning over same-cycle hardware updates.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    // cause bit positions (decoded by software, so fixed)
    localparam int CB_SLOW     = 0;
    localparam int CB_SLOW_N   = 1;
    localparam int CB_FAST     = 2;
    localparam int CB_FAST_N   = 3;
    localparam int CB_CMP_FULL = 4;
    localparam int CB_CMP_LOW  = 5;
    localparam logic [DATA_W-1:0] CAUSE_TIED = 32'h0000_00C0;

    // register index = bus_addr[6:4]
    typedef enum logic [2:0] {
        RG_HANDLER = 3'd0,
        RG_CAUSE   = 3'd1,
        RG_MASK    = 3'd2,
        RG_ENABLE  = 3'd3,
        RG_RETADDR = 3'd4,
        RG_COUNT   = 3'd5,
        RG_CMP     = 3'd6,
        RG_CMP2    = 3'd7
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CAUSE   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RETADDR = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h50;

    typedef struct packed {
        logic [DATA_W-1:0] handler;
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] retaddr;
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] cmp;
        logic [DATA_W-1:0] cmp2;
        logic              squash;
    } ctl_regs_t;

endpackage

// File: rtl/irq_enable_delay.sv
module irq_enable_delay #(
    parameter int W      = 32,
    parameter int STAGES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic [W-1:0] enable
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
        logic [W-1:0]             en;
    } dly_t;

    dly_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (advance) begin
            s_d.en = s_q.stage[0];
            for (int i = 0; i < LAST; i++) begin
                s_d.stage[i] = s_q.stage[i+1];
            end
        end
        if (clear) begin
            s_d = '0;
        end
        if (load) begin
            s_d.stage[LAST] = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign enable = s_q.en;
endmodule

// File: rtl/irq_cause_gen.sv
module irq_cause_gen
    import irq_timer_pkg::*;
#(
    parameter int W         = 32,
    parameter int FAST_TAP  = 16,
    parameter int SLOW_TAP  = 18,
    parameter int CMP2_BITS = 24
) (
    input  logic [W-1:0] cause_cur,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] cmp_full,
    input  logic [W-1:0] cmp_low,
    output logic [W-1:0] cause_new
);
    always_comb begin
        cause_new = cause_cur;
        if (cnt_next == cmp_full) begin
            cause_new[CB_CMP_FULL] = 1'b1;
        end
        if (cnt_next[CMP2_BITS-1:0] == cmp_low[CMP2_BITS-1:0]) begin
            cause_new[CB_CMP_LOW] = 1'b1;
        end
        cause_new[CB_FAST]   = cnt_next[FAST_TAP];
        cause_new[CB_FAST_N] = ~cnt_next[FAST_TAP];
        cause_new[CB_SLOW]   = cnt_next[SLOW_TAP];
        cause_new[CB_SLOW_N] = ~cnt_next[SLOW_TAP];
    end
endmodule

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
    import irq_timer_pkg::*;
#(
    parameter int DLY_STAGES = 4,
    parameter int FAST_TAP   = 16,
    parameter int SLOW_TAP   = 18,
    parameter int CMP2_BITS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              step,
    input  logic              in_delay_slot,
    input  logic [DATA_W-1:0] pc_cur,
    output logic              take_irq,
    output logic [DATA_W-1:0] irq_target,
    output logic              squash
);
    localparam int PC_INC = 4;

    ctl_regs_t r_d, r_q;

    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] cnt_inc;
    logic [DATA_W-1:0] cause_hw;
    logic              addr_ok;
    reg_sel_e          sel;
    logic              wr_enable;
    logic              take;
    logic              normal_step;

    assign addr_ok   = (bus_addr[3:0] == 4'd0) && (bus_addr[ADDR_W-1] == 1'b0);
    assign sel       = reg_sel_e'(bus_addr[6:4]);
    assign wr_enable = bus_we && addr_ok && (sel == RG_ENABLE);
    assign cnt_inc   = r_q.count + 1'b1;

    assign take = step && !r_q.squash && !in_delay_slot
                  && (enable_q != '0) && ((r_q.cause & r_q.mask) != '0);
    assign normal_step = step && !take && !r_q.squash;

    irq_cause_gen #(
        .W(DATA_W), .FAST_TAP(FAST_TAP), .SLOW_TAP(SLOW_TAP), .CMP2_BITS(CMP2_BITS)
    ) u_cause (
        .cause_cur (r_q.cause),
        .cnt_next  (cnt_inc),
        .cmp_full  (r_q.cmp),
        .cmp_low   (r_q.cmp2),
        .cause_new (cause_hw)
    );

    irq_enable_delay #(
        .W(DATA_W), .STAGES(DLY_STAGES)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (take || (wr_enable && bus_wdata == '0)),
        .load     (wr_enable && bus_wdata != '0),
        .load_val (bus_wdata),
        .advance  (step && !take),
        .enable   (enable_q)
    );

    always_comb begin
        r_d = r_q;
        if (normal_step) begin
            r_d.count = cnt_inc;
            r_d.cause = cause_hw;
        end
        if (take) begin
            r_d.retaddr = pc_cur + PC_INC;
            r_d.squash  = 1'b1;
        end else if (step) begin
            r_d.squash  = 1'b0;
        end
        // bus writes override same-cycle hardware updates
        if (bus_we && addr_ok) begin
            unique case (sel)
                RG_HANDLER: r_d.handler = bus_wdata;
                RG_CAUSE:   r_d.cause   = bus_wdata;
                RG_MASK:    r_d.mask    = bus_wdata;
                RG_ENABLE:  ;
                RG_RETADDR: r_d.retaddr = bus_wdata;
                RG_COUNT:   r_d.count   = bus_wdata;
                RG_CMP: begin
                    r_d.cmp = bus_wdata;
                    r_d.cause[CB_CMP_FULL] = 1'b0;
                end
                RG_CMP2: begin
                    r_d.cmp2 = bus_wdata;
                    r_d.cause[CB_CMP_LOW] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (sel)
                RG_HANDLER: bus_rdata = r_q.handler;
                RG_CAUSE:   bus_rdata = r_q.cause | CAUSE_TIED;
                RG_MASK:    bus_rdata = r_q.mask;
                RG_ENABLE:  bus_rdata = enable_q;
                RG_RETADDR: bus_rdata = r_q.retaddr;
                RG_COUNT:   bus_rdata = r_q.count;
                RG_CMP:     bus_rdata = r_q.cmp;
                RG_CMP2:    bus_rdata = r_q.cmp2;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign take_irq   = take;
    assign irq_target = r_q.handler;
    assign squash     = r_q.squash;
endmodule

// File: rtl/irq_timer_ctrl_chk.sv
module irq_timer_ctrl_chk
    import irq_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              step,
    input logic              in_delay_slot,
    input logic [DATA_W-1:0] pc_cur,
    input logic              take_irq,
    input logic              squash,
    input logic [DATA_W-1:0] enable_q,
    input logic [DATA_W-1:0] retaddr_q,
    input logic [DATA_W-1:0] count_q
);
    AST_CAUSE_TIED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CAUSE) |-> (bus_rdata[7:6] == 2'b11)); // R6

    AST_NO_TAKE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        in_delay_slot |-> !take_irq); // R9

    AST_TAKE_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (enable_q == '0)); // R8

    AST_TAKE_SAVES_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !(bus_we && bus_addr == OFS_RETADDR))
        |=> (retaddr_q == $past(pc_cur) + 32'd4)); // R8

    AST_SQUASH_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> squash); // R10

    AST_COUNT_ONE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !take_irq && !squash && !(bus_we && bus_addr == OFS_COUNT))
        |=> (count_q == $past(count_q) + 32'd1)); // R2

    AST_COUNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !bus_we) |=> $stable(count_q)); // R2

    AST_ZERO_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ENABLE && bus_wdata == '0) |=> (enable_q == '0)); // R7
endmodule

bind irq_timer_ctrl irq_timer_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .step          (step),
    .in_delay_slot (in_delay_slot),
    .pc_cur        (pc_cur),
    .take_irq      (take_irq),
    .squash        (squash),
    .enable_q      (enable_q),
    .retaddr_q     (r_q.retaddr),
    .count_q       (r_q.count)
);

// File: tb/irq_timer_ctrl_bench.sv
module irq_timer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        step = 1'b0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] pc_cur = '0;
    logic        take_irq;
    logic [31:0] irq_target;
    logic        squash;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [7:0] A_HND = 8'h00, A_CAU = 8'h10, A_MSK = 8'h20, A_ENA = 8'h30,
                           A_RET = 8'h40, A_CNT = 8'h50, A_CMP = 8'h60, A_CMP2 = 8'h70;

    always #5 clk = ~clk;

    irq_timer_ctrl u_irq_timer_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .step(step),
        .in_delay_slot(in_delay_slot), .pc_cur(pc_cur), .take_irq(take_irq),
        .irq_target(irq_target), .squash(squash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic st, input logic slot, input logic [31:0] pc);
        bus_we = we; bus_addr = a; bus_wdata = d;
        step = st; in_delay_slot = slot; pc_cur = pc;
        @(negedge clk);
        bus_we = 1'b0; step = 1'b0; in_delay_slot = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick(1'b1, a, d, 1'b0, 1'b0, '0);
    endtask

    task automatic stp();
        tick(1'b0, 8'h00, '0, 1'b1, 1'b0, '0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] tap_bits(input logic [31:0] c);
        return {28'd0, ~c[16], c[16], ~c[18], c[18]};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_HND, v); chk("R1 handler reset", v, 32'h0);
        rd(A_CAU, v); chk("R1/R6 cause reset", v, 32'hC0);
        rd(A_ENA, v); chk("R1 enable reset", v, 32'h0);
        rd(A_CNT, v); chk("R1 counter reset", v, 32'h0);
        chk("R1 take reset", {31'd0, take_irq}, 32'h0);
        chk("R1 squash reset", {31'd0, squash}, 32'h0);

        // R1: register readback
        wr(A_HND, 32'h8000_0100); rd(A_HND, v); chk("R1 handler rw", v, 32'h8000_0100);
        chk("R8 target is handler", irq_target, 32'h8000_0100);
        wr(A_MSK, 32'h0000_00A5); rd(A_MSK, v); chk("R1 mask rw", v, 32'h0000_00A5);
        wr(A_RET, 32'h1234_5678); rd(A_RET, v); chk("R1 retaddr rw", v, 32'h1234_5678);
        wr(A_CAU, 32'h0000_0300); rd(A_CAU, v); chk("R6 cause rw tied", v, 32'h0000_03C0);

        // R2: counter steps, idle holds
        wr(A_CNT, 32'h0000_0010);
        stp(); stp(); stp();
        rd(A_CNT, v); chk("R2 three steps", v, 32'h13);
        @(negedge clk); @(negedge clk);
        rd(A_CNT, v); chk("R2 idle hold", v, 32'h13);

        // R5: tap sweep across bit16 and bit18 transitions
        wr(A_CMP, 32'hFFFF_FFFF);
        wr(A_CMP2, 32'h00FF_FFFF);
        for (int i = 0; i < 48; i++) begin
            logic [31:0] nxt;
            nxt = (i + 1) * 32'h2000;
            wr(A_CAU, 32'h0);
            wr(A_CNT, nxt - 1);
            stp();
            rd(A_CAU, v);
            chk("R5 taps", v, tap_bits(nxt) | 32'hC0);
        end

        // R3: full compare
        wr(A_CAU, 32'h0);
        wr(A_CMP, 32'h1234_5678);
        wr(A_CNT, 32'h1234_5677);
        stp();
        rd(A_CAU, v); chk("R3 full match", v[4], 1'b1);
        stp();
        rd(A_CAU, v); chk("R3 sticky", v[4], 1'b1);
        wr(A_CMP, 32'hFFFF_FFFF);
        rd(A_CAU, v); chk("R3 write clears", v[4], 1'b0);
        wr(A_CMP, 32'h2234_5678);
        wr(A_CNT, 32'h1234_5677);
        stp();
        rd(A_CAU, v); chk("R3 high byte differs", v[4], 1'b0);
        wr(A_CMP, 32'hFFFF_FFFF);

        // R4: compare2 low-24 match with arbitrary high bytes
        for (int h = 0; h < 16; h++) begin
            wr(A_CMP2, {h[7:0], 24'h000123});
            rd(A_CAU, v); chk("R4 write clears", v[5], 1'b0);
            wr(A_CNT, {h[7:0] ^ 8'h5A, 24'h000122});
            stp();
            rd(A_CAU, v); chk("R4 low match", v[5], 1'b1);
        end
        wr(A_CMP2, 32'h0000_0000);
        wr(A_CNT, 32'h00FF_FFFF);
        stp();
        rd(A_CAU, v); chk("R4 24-bit wrap", v[5], 1'b1);
        wr(A_CMP2, 32'h0000_0007);
        wr(A_CNT, 32'h0100_0005);
        stp();
        rd(A_CAU, v); chk("R4 no match", v[5], 1'b0);
        wr(A_CMP2, 32'h00FF_FFFF);

        // R7: enable delay line, idle cycles interleaved
        for (int p = 0; p < 4; p++) begin
            logic [31:0] val;
            val = 32'h1 << (p * 7);
            wr(A_ENA, val);
            for (int n = 1; n <= 6; n++) begin
                stp();
                @(negedge clk);
                rd(A_ENA, v);
                chk("R7 delay", v, (n >= 4) ? val : 32'h0);
            end
            wr(A_ENA, 32'h0);
            rd(A_ENA, v); chk("R7 zero clears", v, 32'h0);
            stp(); stp(); stp(); stp();
            rd(A_ENA, v); chk("R7 line cleared", v, 32'h0);
        end

        // R11: bus write wins over same-cycle step
        wr(A_CNT, 32'h0);
        tick(1'b1, A_CAU, 32'h0, 1'b1, 1'b0, '0);
        rd(A_CAU, v); chk("R11 cause write wins", v, 32'hC0);
        tick(1'b1, A_CNT, 32'h0000_0100, 1'b1, 1'b0, '0);
        rd(A_CNT, v); chk("R11 counter write wins", v, 32'h100);

        // R8/R9/R10: interrupt take
        wr(A_HND, 32'h8000_0200);
        wr(A_MSK, 32'h2);
        wr(A_CNT, 32'h0);
        wr(A_ENA, 32'h1);
        stp(); stp(); stp();
        chk("R8 no take before enable", {31'd0, take_irq}, 32'h0);
        stp();
        rd(A_ENA, v); chk("R7 enable set", v, 32'h1);
        rd(A_CNT, c0);
        // delay slot: no take, normal step
        bus_addr = A_CNT; step = 1'b1; in_delay_slot = 1'b1; pc_cur = 32'h40;
        #1;
        chk("R9 no take in slot", {31'd0, take_irq}, 32'h0);
        @(negedge clk);
        step = 1'b0; in_delay_slot = 1'b0;
        rd(A_CNT, v); chk("R9 slot counts", v, c0 + 1);
        c0 = v;
        // take
        step = 1'b1; pc_cur = 32'h0000_0200;
        #1;
        chk("R8 take", {31'd0, take_irq}, 32'h1);
        chk("R8 target", irq_target, 32'h8000_0200);
        @(negedge clk);
        step = 1'b0;
        rd(A_RET, v); chk("R8 retaddr", v, 32'h0000_0204);
        rd(A_ENA, v); chk("R8 enable cleared", v, 32'h0);
        rd(A_CNT, v); chk("R8 take no count", v, c0);
        chk("R10 squash high", {31'd0, squash}, 32'h1);
        // squashed step
        wr(A_CAU, 32'h0);
        step = 1'b1;
        #1;
        chk("R10 no take on squash", {31'd0, take_irq}, 32'h0);
        @(negedge clk);
        step = 1'b0;
        rd(A_CNT, v); chk("R10 squash no count", v, c0);
        rd(A_CAU, v); chk("R10 squash no cause", v, 32'hC0);
        chk("R10 squash drops", {31'd0, squash}, 32'h0);
        stp(); stp(); stp(); stp();
        rd(A_ENA, v); chk("R8 delay line cleared", v, 32'h0);
        rd(A_CNT, v); chk("R2 resumes", v, c0 + 4);

        done = 1;
        finish_run();
    end
endmodule